// File: doc/BRIEF.md
# Per-Event Hit Readout Controller

This block collects, for each triggered event, the matched hits held in 32 channel readout queues and packs them into one self-describing block. Every accepted trigger leaves its event number and trigger bunch-crossing value in a small internal queue, stamped with the cycle of its arrival. Once a programmable latency has elapsed, the controller broadcasts the event number to all channels with a one-cycle compare-enable. It then reads the 32 per-channel match flags in one strobe. Channels that are behind discard their stale entries themselves.

The controller services flagged channels in ascending index order. It drives the channel index on a 5-bit select and pulses a read-enable to fetch one entry. A channel stays selected for as long as its flag remains high. Each fetched hit is buffered in a local hit store together with its wire code, which is the channel index. When collection ends, the controller waits until the output queue can take the whole block. It then writes an event word, a count word, the hit words and an end word. A block is written even when it carries no hits. A backplane reader drains the output queue through a first-word-fall-through read port.

Top module: `evr_readout_ctrl`

## Requirements
- R1: After reset the output queue is empty, and `cmp_en`, `flag_rd`, `ch_re` and `blk_stall` are low, with `bcast_evt` at zero.
- R2: Triggers are queued and served in arrival order. When the controller is idle and `delay_cfg` = D ≥ 1, `cmp_en` is high for exactly one cycle. That cycle begins D clock edges after the edge that accepts the trigger, and `bcast_evt` carries the trigger's event number in it.
- R3: `flag_rd` is high in the cycle right after `cmp_en`, and the controller samples `hit_flags` at the end of that cycle.
- R4: Among the sampled flags, channels are read in ascending index order, with `ch_sel` driving the channel index.
- R5: Each read is a single-cycle `ch_re` pulse. After each read the selected channel's live flag is examined, and while it stays high the same channel is read again.
- R6: Each word is 2 tag bits over a 21-bit payload. The tags are 00 event, 01 count, 10 hit and 11 end. The words appear in the order event, count, hits, end. The event payload is {event number, trigger bunch crossing}. The count payload is the number of hit words. The hit payload is {5-bit wire code, 16-bit hit data}. The end payload is the event number. All payloads are zero-extended.
- R7: An event whose sampled flags are all zero still produces a three-word block with a count of 0.
- R8: At most MAXHIT (8) hits are collected per event, and no read is issued once the hit store is full. Entries left in a channel are not read for that event.
- R9: When the output queue's free space is smaller than the hit count plus 3, `blk_stall` is high and no word is written. Writing starts once the space is available.
- R10: `bcast_evt` holds the event number under service, unchanged, through all of that event's channel reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger accept strobe |
| trig_evt | input | 8 | Event number of the trigger |
| trig_bx | input | 12 | Trigger bunch-crossing value |
| delay_cfg | input | 16 | Readout latency in cycles |
| bcast_evt | output | 8 | Event number broadcast to channels |
| cmp_en | output | 1 | Channels latch `bcast_evt` |
| flag_rd | output | 1 | Match-flag read strobe |
| hit_flags | input | 32 | Per-channel match flags |
| ch_sel | output | 5 | Selected channel index |
| ch_re | output | 1 | Read one entry from the selected channel |
| ch_data | input | 16 | Head entry of the selected channel |
| out_rd | input | 1 | Pop one word from the output queue |
| out_data | output | 23 | Head word of the output queue |
| out_empty | output | 1 | Output queue empty |
| blk_stall | output | 1 | Finished block waits for output space |

## Verification
The hardest state to reach is a stall. It needs a finished block while the output queue still holds an earlier block that nobody has drained. The stimulus first sends an event that fills the hit store to its limit, giving an 11-word block, and deliberately leaves it unread. A second event with three hits then needs 6 words against only 5 free. The bench observes the stall before it drains the first block. The bench's channel model discards stale entries when the event number is broadcast. This exposes the skipping of older data and the repeated reads of a channel holding several hits.

// File: rtl/evr_pkg.sv
package evr_pkg;

    typedef enum logic [1:0] {
        TAG_EVT = 2'b00,
        TAG_CNT = 2'b01,
        TAG_HIT = 2'b10,
        TAG_END = 2'b11
    } word_tag_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BCAST,
        ST_SAMPLE,
        ST_PICK,
        ST_READ,
        ST_CHECK,
        ST_WAIT,
        ST_HEVT,
        ST_HCNT,
        ST_HITS,
        ST_END
    } ctrl_state_t;

    // words added around the hits of a block
    localparam int BLK_OVH = 3;

    function automatic int blk_words(input int hits);
        return hits + BLK_OVH;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/evr_fifo.sv
module evr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end
endmodule

// File: rtl/evr_prio.sv
module evr_prio #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N-1:0] below;
    logic [N-1:0] grant;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_grant
            if (g == 0) begin : g_first
                assign below[g] = 1'b0;
            end else begin : g_rest
                assign below[g] = below[g-1] | req[g-1];
            end
            assign grant[g] = req[g] & ~below[g];
        end
    endgenerate

    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/evr_readout_ctrl.sv
module evr_readout_ctrl
    import evr_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int EVW    = 8,
    parameter int BXW    = 12,
    parameter int TSW    = 16,
    parameter int DW     = 16,
    parameter int TQD    = 4,
    parameter int MAXHIT = 8,
    parameter int OFD    = 16,
    parameter int SELW   = $clog2(NCH),
    parameter int PW     = imax(SELW + DW, EVW + BXW),
    parameter int OW     = 2 + PW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig_valid,
    input  logic [EVW-1:0]  trig_evt,
    input  logic [BXW-1:0]  trig_bx,
    input  logic [TSW-1:0]  delay_cfg,
    output logic [EVW-1:0]  bcast_evt,
    output logic            cmp_en,
    output logic            flag_rd,
    input  logic [NCH-1:0]  hit_flags,
    output logic [SELW-1:0] ch_sel,
    output logic            ch_re,
    input  logic [DW-1:0]   ch_data,
    input  logic            out_rd,
    output logic [OW-1:0]   out_data,
    output logic            out_empty,
    output logic            blk_stall
);
    localparam int HITW = SELW + DW;
    localparam int TQCW = $clog2(TQD + 1);
    localparam int STCW = $clog2(MAXHIT + 1);
    localparam int OCW  = $clog2(OFD + 1);

    typedef struct packed {
        logic [EVW-1:0] evt;
        logic [BXW-1:0] bx;
        logic [TSW-1:0] stamp;
    } trig_ent_t;

    ctrl_state_t     st;
    logic [TSW-1:0]  tnow;
    logic [NCH-1:0]  flags_q;
    logic [SELW-1:0] sel_q;
    logic [EVW-1:0]  cur_evt;
    logic [BXW-1:0]  cur_bx;
    logic [STCW-1:0] cnt_q;

    // trigger queue
    trig_ent_t       tq_wdata, tq_head;
    logic            tq_empty, tq_full, tq_pop, tq_ready;
    logic [TQCW-1:0] tq_cnt;
    logic [TSW-1:0]  elapsed;

    // hit store
    logic [HITW-1:0] hs_wdata, hs_rdata;
    logic            hs_push, hs_pop, hs_empty, hs_full;
    logic [STCW-1:0] hs_cnt;

    // output queue
    logic [OW-1:0]   out_wdata;
    logic            out_push, out_full;
    logic [OCW-1:0]  out_cnt;
    logic            room;

    // priority pick
    logic [SELW-1:0] pr_idx;
    logic            pr_any;

    assign tq_wdata = '{evt: trig_evt, bx: trig_bx, stamp: tnow};

    evr_fifo #(.W($bits(trig_ent_t)), .DEPTH(TQD)) u_trig_q (
        .clk(clk), .rst(rst),
        .push(trig_valid), .wdata(tq_wdata),
        .pop(tq_pop), .rdata(tq_head),
        .empty(tq_empty), .full(tq_full), .count(tq_cnt)
    );

    evr_fifo #(.W(HITW), .DEPTH(MAXHIT)) u_hit_store (
        .clk(clk), .rst(rst),
        .push(hs_push), .wdata(hs_wdata),
        .pop(hs_pop), .rdata(hs_rdata),
        .empty(hs_empty), .full(hs_full), .count(hs_cnt)
    );

    evr_fifo #(.W(OW), .DEPTH(OFD)) u_out_q (
        .clk(clk), .rst(rst),
        .push(out_push), .wdata(out_wdata),
        .pop(out_rd), .rdata(out_data),
        .empty(out_empty), .full(out_full), .count(out_cnt)
    );

    evr_prio #(.N(NCH), .IW(SELW)) u_pick (
        .req(flags_q), .idx(pr_idx), .any(pr_any)
    );

    assign elapsed  = tnow - tq_head.stamp;
    assign tq_ready = !tq_empty && (elapsed >= delay_cfg);
    assign room     = (OFD - int'(out_cnt)) >= blk_words(int'(hs_cnt));

    assign bcast_evt = cur_evt;
    assign cmp_en    = (st == ST_BCAST);
    assign flag_rd   = (st == ST_SAMPLE);
    assign ch_re     = (st == ST_READ);
    assign ch_sel    = sel_q;
    assign blk_stall = (st == ST_WAIT) && !room;

    assign hs_push  = ch_re;
    assign hs_wdata = {sel_q, ch_data};
    assign hs_pop   = (st == ST_HITS);
    assign tq_pop   = (st == ST_END);

    always_comb begin
        out_push  = 1'b1;
        out_wdata = '0;
        case (st)
            ST_HEVT: out_wdata = {TAG_EVT, PW'({cur_evt, cur_bx})};
            ST_HCNT: out_wdata = {TAG_CNT, PW'(cnt_q)};
            ST_HITS: out_wdata = {TAG_HIT, PW'(hs_rdata)};
            ST_END:  out_wdata = {TAG_END, PW'(cur_evt)};
            default: out_push  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            tnow    <= '0;
            flags_q <= '0;
            sel_q   <= '0;
            cur_evt <= '0;
            cur_bx  <= '0;
            cnt_q   <= '0;
        end else begin
            tnow <= tnow + 1'b1;
            case (st)
                ST_IDLE: begin
                    if (tq_ready) begin
                        cur_evt <= tq_head.evt;
                        cur_bx  <= tq_head.bx;
                        st      <= ST_BCAST;
                    end
                end
                ST_BCAST:  st <= ST_SAMPLE;
                ST_SAMPLE: begin
                    flags_q <= hit_flags;
                    st      <= ST_PICK;
                end
                ST_PICK: begin
                    if (!pr_any || hs_full) begin
                        st <= ST_WAIT;
                    end else begin
                        sel_q <= pr_idx;
                        st    <= ST_READ;
                    end
                end
                ST_READ:  st <= ST_CHECK;
                ST_CHECK: begin
                    if (hit_flags[sel_q] && !hs_full) begin
                        st <= ST_READ;
                    end else begin
                        flags_q[sel_q] <= 1'b0;
                        st             <= ST_PICK;
                    end
                end
                ST_WAIT: begin
                    if (room) begin
                        cnt_q <= hs_cnt;
                        st    <= ST_HEVT;
                    end
                end
                ST_HEVT: st <= ST_HCNT;
                ST_HCNT: st <= (cnt_q == '0) ? ST_END : ST_HITS;
                ST_HITS: begin
                    if (hs_cnt == STCW'(1)) st <= ST_END;
                end
                ST_END:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/evr_checker.sv
module evr_checker #(
    parameter int EVW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cmp_en,
    input logic           flag_rd,
    input logic           ch_re,
    input logic [EVW-1:0] bcast_evt,
    input logic           blk_stall,
    input logic           out_push,
    input logic           hs_full
);
    // R2: compare-enable lasts one cycle
    a_r2_cmp_single: assert property (@(posedge clk) disable iff (rst)
        cmp_en |=> !cmp_en);

    // R3: flag read follows the broadcast
    a_r3_flag_after_cmp: assert property (@(posedge clk) disable iff (rst)
        cmp_en |=> flag_rd);

    // R5: each channel read is a single pulse
    a_r5_re_pulse: assert property (@(posedge clk) disable iff (rst)
        ch_re |=> !ch_re);

    // R8: never read a channel with the hit store full
    a_r8_store_room: assert property (@(posedge clk) disable iff (rst)
        ch_re |-> !hs_full);

    // R9: nothing is written while stalled
    a_r9_no_write_stalled: assert property (@(posedge clk) disable iff (rst)
        blk_stall |-> !out_push);

    // R10: broadcast event number steady during reads
    a_r10_evt_held: assert property (@(posedge clk) disable iff (rst)
        ch_re |-> $stable(bcast_evt));
endmodule

bind evr_readout_ctrl evr_checker #(.EVW(EVW)) u_evr_chk (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .flag_rd(flag_rd),
    .ch_re(ch_re), .bcast_evt(bcast_evt), .blk_stall(blk_stall),
    .out_push(out_push), .hs_full(hs_full)
);

// File: tb/evr_readout_ctrl_bench.sv
module evr_readout_ctrl_bench;
    localparam int NCH = 32;
    localparam int EVW = 8;
    localparam int BXW = 12;
    localparam int TSW = 16;
    localparam int DW  = 16;
    localparam int PW  = 21;
    localparam int OW  = 23;
    localparam int QD  = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           trig_valid = 1'b0;
    logic [EVW-1:0] trig_evt = '0;
    logic [BXW-1:0] trig_bx = '0;
    logic [TSW-1:0] delay_cfg = 16'd5;
    logic [EVW-1:0] bcast_evt;
    logic           cmp_en, flag_rd, ch_re, out_empty, blk_stall;
    logic [NCH-1:0] hit_flags;
    logic [4:0]     ch_sel;
    logic [DW-1:0]  ch_data;
    logic           out_rd = 1'b0;
    logic [OW-1:0]  out_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    evr_readout_ctrl u_evr_readout_ctrl (
        .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_evt(trig_evt),
        .trig_bx(trig_bx), .delay_cfg(delay_cfg), .bcast_evt(bcast_evt),
        .cmp_en(cmp_en), .flag_rd(flag_rd), .hit_flags(hit_flags),
        .ch_sel(ch_sel), .ch_re(ch_re), .ch_data(ch_data), .out_rd(out_rd),
        .out_data(out_data), .out_empty(out_empty), .blk_stall(blk_stall)
    );

    // ---------------- channel model ----------------
    logic [EVW-1:0] m_evt [NCH][QD];
    logic [DW-1:0]  m_dat [NCH][QD];
    int             m_hd  [NCH];
    int             m_cnt [NCH];
    logic [EVW-1:0] lat_evt;
    logic           lat_v;
    logic           ld_valid = 1'b0;
    int             ld_ch = 0;
    logic [EVW-1:0] ld_evt = '0;
    logic [DW-1:0]  ld_dat = '0;

    always @(posedge clk) begin
        if (rst) begin
            lat_v   <= 1'b0;
            lat_evt <= '0;
            for (int ch = 0; ch < NCH; ch++) begin
                m_hd[ch]  <= 0;
                m_cnt[ch] <= 0;
            end
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                automatic int h = m_hd[ch];
                automatic int c = m_cnt[ch];
                if (cmp_en) begin
                    while (c > 0 && m_evt[ch][h % QD] < bcast_evt) begin
                        h++;
                        c--;
                    end
                end
                if (ch_re && int'(ch_sel) == ch && c > 0) begin
                    h++;
                    c--;
                end
                if (ld_valid && ld_ch == ch) begin
                    m_evt[ch][(h + c) % QD] <= ld_evt;
                    m_dat[ch][(h + c) % QD] <= ld_dat;
                    c++;
                end
                m_hd[ch]  <= h % QD;
                m_cnt[ch] <= c;
            end
            if (cmp_en) begin
                lat_evt <= bcast_evt;
                lat_v   <= 1'b1;
            end
        end
    end

    always_comb begin
        for (int ch = 0; ch < NCH; ch++)
            hit_flags[ch] = lat_v && (m_cnt[ch] > 0) && (m_evt[ch][m_hd[ch]] == lat_evt);
    end
    assign ch_data = m_dat[ch_sel][m_hd[ch_sel]];

    // read log
    int             log_n = 0;
    logic [4:0]     log_sel [64];
    logic [EVW-1:0] log_evt [64];
    always @(negedge clk) begin
        if (ch_re && log_n < 64) begin
            log_sel[log_n] <= ch_sel;
            log_evt[log_n] <= bcast_evt;
            log_n <= log_n + 1;
        end
    end

    // ---------------- helpers ----------------
    int e_code [16];
    int e_dat  [16];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic load_hit(input int ch, input int evt, input int dat);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_ch    = ch;
        ld_evt   = EVW'(evt);
        ld_dat   = DW'(dat);
    endtask

    task automatic load_done();
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic fire(input int evt, input int bx);
        @(negedge clk);
        trig_valid = 1'b1;
        trig_evt   = EVW'(evt);
        trig_bx    = BXW'(bx);
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic pop_word(input string req, output int w);
        int t;
        t = 0;
        while (out_empty && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (out_empty) begin
            checks++;
            errors++;
            $display("FAIL %s: actual no word expected a word", req);
            w = -1;
        end else begin
            w = int'(out_data);
            out_rd = 1'b1;
            @(negedge clk);
            out_rd = 1'b0;
        end
    endtask

    task automatic check_block(input string req, input int evt, input int bx, input int n);
        int w;
        pop_word(req, w);
        chk({req, " event word"}, w, int'({2'b00, PW'({EVW'(evt), BXW'(bx)})}));
        pop_word(req, w);
        chk({req, " count word"}, w, int'({2'b01, PW'(n)}));
        for (int i = 0; i < n; i++) begin
            pop_word(req, w);
            chk({req, " hit word"}, w, int'({2'b10, PW'({5'(e_code[i]), DW'(e_dat[i])})}));
        end
        pop_word(req, w);
        chk({req, " end word"}, w, int'({2'b11, PW'(EVW'(evt))}));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 out_empty", int'(out_empty), 1);
        chk("R1 cmp_en", int'(cmp_en), 0);
        chk("R1 flag_rd", int'(flag_rd), 0);
        chk("R1 ch_re", int'(ch_re), 0);
        chk("R1 blk_stall", int'(blk_stall), 0);
        chk("R1 bcast_evt", int'(bcast_evt), 0);
    endtask

    task automatic t_latency_empty();
        int n;
        @(negedge clk);
        trig_valid = 1'b1;
        trig_evt   = 8'd1;
        trig_bx    = 12'h0A1;
        @(negedge clk);
        trig_valid = 1'b0;
        n = 0;
        while (!cmp_en && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R2 latency", n, 5);
        chk("R2 broadcast event", int'(bcast_evt), 1);
        @(negedge clk);
        chk("R2 cmp single cycle", int'(cmp_en), 0);
        chk("R3 flag_rd after cmp", int'(flag_rd), 1);
        check_block("R7 empty block", 1, 12'h0A1, 0);
    endtask

    task automatic t_order();
        int s;
        s = log_n;
        load_hit(2, 1, 16'h1111);
        load_hit(2, 2, 16'h2222);
        load_hit(7, 2, 16'h7001);
        load_hit(7, 2, 16'h7002);
        load_hit(30, 2, 16'h3E00);
        load_done();
        fire(2, 12'h0B2);
        e_code[0] = 2;  e_dat[0] = 16'h2222;
        e_code[1] = 7;  e_dat[1] = 16'h7001;
        e_code[2] = 7;  e_dat[2] = 16'h7002;
        e_code[3] = 30; e_dat[3] = 16'h3E00;
        check_block("R6 block format", 2, 12'h0B2, 4);
        chk("R4 reads issued", log_n - s, 4);
        chk("R4 first channel", int'(log_sel[s]), 2);
        chk("R5 repeat channel", int'(log_sel[s+1]), 7);
        chk("R5 repeat channel", int'(log_sel[s+2]), 7);
        chk("R4 last channel", int'(log_sel[s+3]), 30);
        chk("R10 event during reads", int'(log_evt[s+3]), 2);
    endtask

    task automatic t_limit_stall();
        int s;
        for (int i = 0; i < 10; i++) load_hit(3, 3, 16'h3000 + i);
        load_done();
        fire(3, 12'h0C3);
        repeat (60) @(negedge clk);
        chk("R9 no stall with room", int'(blk_stall), 0);
        s = log_n;
        load_hit(9, 4, 16'h9001);
        load_hit(9, 4, 16'h9002);
        load_hit(9, 4, 16'h9003);
        load_done();
        fire(4, 12'h0D4);
        repeat (40) @(negedge clk);
        chk("R9 stall raised", int'(blk_stall), 1);
        chk("R8 reads for event 4", log_n - s, 3);
        for (int i = 0; i < 8; i++) begin
            e_code[i] = 3;
            e_dat[i]  = 16'h3000 + i;
        end
        check_block("R8 hit limit", 3, 12'h0C3, 8);
        for (int i = 0; i < 3; i++) begin
            e_code[i] = 9;
            e_dat[i]  = 16'h9001 + i;
        end
        check_block("R9 block after stall", 4, 12'h0D4, 3);
        chk("R9 stall cleared", int'(blk_stall), 0);
    endtask

    task automatic t_back_to_back();
        load_hit(0, 5, 16'h5005);
        load_hit(31, 6, 16'h6006);
        load_done();
        fire(5, 12'h0E5);
        fire(6, 12'h0F6);
        e_code[0] = 0;  e_dat[0] = 16'h5005;
        check_block("R2 first trigger first", 5, 12'h0E5, 1);
        e_code[0] = 31; e_dat[0] = 16'h6006;
        check_block("R2 second trigger next", 6, 12'h0F6, 1);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency_empty();
        t_order();
        t_limit_stall();
        t_back_to_back();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule